// File: doc/BRIEF.md
# Byte-Serial SM4 Round-Key Generator

This block expands a 128-bit SM4 cipher key into the 32 encryption round keys and hands them to a byte-serial cipher datapath one byte per clock. A pulse on `start` captures the key, mixes it with the fixed family key and begins the expansion. Every round takes six clocks. Four of those clocks push one byte through a shared S-box. One clock folds the resulting word through the key-schedule linear transform and retires the oldest key word. The per-round constant bytes are not stored. A small adder makes each byte by adding seven to the byte before it.

The generator works one full six-cycle round ahead of the consumer. While round key *i+1* is being computed, round key *i* is replayed from a holding register, most significant byte first, on four consecutive cycles marked by `rk_valid`. A full run takes 198 cycles from the `start` edge. After the last byte the output keeps its value and the strobe stays low until the next `start`. The schedule is unmasked and produces keys in encryption order only.

Top module: `sm4_keysched_serial`

## Requirements
- R1: On the clock edge where `start` is high, the four key words are loaded with `master_key` XOR the family constant A3B1BAC6_56AA3350_677D9197_B27022DC, with the most significant word first. The constant bytes and the round counter restart at zero. `start` also aborts a run in progress and begins a new one.
- R2: Round key i equals K0 ^ L'(S(K1 ^ K2 ^ K3 ^ CK_i)). S is applied to each byte and is the SM4 S-box: an affine map, then inversion in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1, then the same affine map again. Check values are S(00)=D6 and S(01)=90. L'(x) = x ^ (x <<< 13) ^ (x <<< 23).
- R3: The constant bytes form a single running sequence that starts at 00, with each byte the previous byte plus 7 modulo 256. Across rounds the sequence continues without restarting, so byte j (0 = most significant) of CK_i is (28·i + 7·j) mod 256, for example CK_0 = 00070E15.
- R4: Each round lasts exactly 6 cycles. At the end of each round the key words shift down by one word (K0 takes the old K1) and the new round key enters as K3.
- R5: Count the `start` edge as edge 0. Byte j of round key i (j = 0 is the most significant byte) is on `rk_byte` with `rk_valid` high in the cycle after edge 6·i + 7 + j, for i = 0..31 and j = 0..3.
- R6: A run that is not aborted gives exactly 32 round keys, 128 valid bytes in all. `rk_valid` is low in every other cycle.
- R7: Once the last byte has gone out, and until the next `start`, `rk_valid` stays low and `rk_byte` holds the least significant byte of round key 31.
- R8: While reset is asserted and after it, with no `start`, `rk_valid` is 0 and `rk_byte` is 00.
- R9: For key 0123456789ABCDEF_FEDCBA9876543210, round key 0 is F12186F9 and round key 31 is 9124A012.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to `clk` |
| start | input | 1 | One-cycle pulse: capture `master_key` and begin a run |
| master_key | input | 128 | Cipher key, sampled only on the `start` edge |
| rk_byte | output | 8 | Current round-key byte, most significant byte of each key first |
| rk_valid | output | 1 | High while `rk_byte` carries a round-key byte |

## Verification
Every result here is due at a fixed clock offset from the `start` edge. Byte j of key i shows up registered after edge 6·i+7+j, which is one round of computation plus one output register. The last byte arrives after edge 196, and the run ends at edge 198. The bench counts the edges after `start` and samples on the falling edge. In each cycle it works out from that count alone whether `rk_valid` must be high and which key byte is due, so a shift by even one cycle shows up as a miscompare. An aborted run is cut off at a known edge and followed at once by a fresh run, which is checked against the same timing.

// File: rtl/sm4ks_pkg.sv
package sm4ks_pkg;

  localparam int unsigned KEY_W          = 128;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned BYTES_PER_WORD = WORD_W / BYTE_W;
  localparam int unsigned KEY_WORDS      = KEY_W / WORD_W;

  // family constant mixed into the cipher key at load
  localparam logic [KEY_W-1:0] FAMILY_KEY =
    128'hA3B1BAC6_56AA3350_677D9197_B27022DC;

  // S-box affine constant and low byte of the field polynomial
  localparam logic [BYTE_W-1:0] AFF_CONST = 8'hD3;
  localparam logic [BYTE_W-1:0] POLY_LOW  = 8'hF5;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

endpackage

// File: rtl/sm4ks_sbox.sv
module sm4ks_sbox
  import sm4ks_pkg::*;
(
  input  byte_t din,
  output byte_t dout
);

  // circulant affine map: bit i takes input bits i, i+1, i+2, i+5, i+7
  function automatic byte_t affine(input byte_t x);
    byte_t y;
    for (int i = 0; i < 8; i++) begin
      y[i] = x[i] ^ x[(i + 1) % 8] ^ x[(i + 2) % 8] ^ x[(i + 5) % 8]
           ^ x[(i + 7) % 8] ^ AFF_CONST[i];
    end
    return y;
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ POLY_LOW) : (sh << 1);
    end
    return acc;
  endfunction

  // x^254 through x^3, x^7, ... x^127, then one square; maps 0 to 0
  function automatic byte_t gf_inv(input byte_t x);
    byte_t r;
    r = x;
    for (int k = 0; k < 6; k++) begin
      r = gf_mul(gf_mul(r, r), x);
    end
    return gf_mul(r, r);
  endfunction

  byte_t pre_map;
  byte_t inv_val;

  always_comb begin
    pre_map = affine(din);
    inv_val = gf_inv(pre_map);
    dout    = affine(inv_val);
  end

endmodule

// File: rtl/sm4ks_lprime.sv
module sm4ks_lprime
  import sm4ks_pkg::*;
#(
  parameter int unsigned ROT_A = 13,
  parameter int unsigned ROT_B = 23
) (
  input  word_t din,
  output word_t dout
);

  word_t rot_a;
  word_t rot_b;

  always_comb begin
    rot_a = (din << ROT_A) | (din >> (WORD_W - ROT_A));
    rot_b = (din << ROT_B) | (din >> (WORD_W - ROT_B));
    dout  = din ^ rot_a ^ rot_b;
  end

endmodule

// File: rtl/sm4ks_ckgen.sv
module sm4ks_ckgen
  import sm4ks_pkg::*;
#(
  parameter int unsigned STEP = 7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  adv,
  output byte_t ck_byte
);

  byte_t ck_q;
  byte_t ck_d;

  always_comb begin
    ck_d = ck_q;
    if (load)      ck_d = '0;
    else if (adv)  ck_d = ck_q + BYTE_W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= '0;
    else        ck_q <= ck_d;
  end

  assign ck_byte = ck_q;

endmodule

// File: rtl/sm4ks_ctrl.sv
module sm4ks_ctrl #(
  parameter  int unsigned ROUNDS = 32,
  parameter  int unsigned PHASES = 6,
  localparam int unsigned PH_W   = $clog2(PHASES),
  localparam int unsigned RD_W   = $clog2(ROUNDS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic [PH_W-1:0] phase,
  output logic [RD_W-1:0] round
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);
  localparam logic [RD_W-1:0] LAST_RD = RD_W'(ROUNDS);

  logic            busy_q,  busy_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic [RD_W-1:0] round_q, round_d;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    round_d = round_q;
    if (start) begin
      busy_d  = 1'b1;
      phase_d = '0;
      round_d = '0;
    end else if (busy_q) begin
      if (phase_q == LAST_PH) begin
        phase_d = '0;
        if (round_q == LAST_RD) busy_d  = 1'b0;
        else                    round_d = round_q + 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      round_q <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      round_q <= round_d;
    end
  end

  assign busy  = busy_q;
  assign phase = phase_q;
  assign round = round_q;

  // R1
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && phase == '0 && round == '0));

  // R4
  round_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && phase != LAST_PH) |=> (round == $past(round)));

  // R6
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && phase == LAST_PH && round == LAST_RD) |=> !busy);

endmodule

// File: rtl/sm4_keysched_serial.sv
module sm4_keysched_serial
  import sm4ks_pkg::*;
#(
  parameter int unsigned ROUNDS  = 32,
  parameter int unsigned PHASES  = 6,
  parameter int unsigned CK_STEP = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] master_key,
  output logic [BYTE_W-1:0] rk_byte,
  output logic             rk_valid
);

  localparam int unsigned PH_W  = $clog2(PHASES);
  localparam int unsigned RD_W  = $clog2(ROUNDS + 1);
  localparam int unsigned SEL_W = $clog2(BYTES_PER_WORD);
  localparam logic [PH_W-1:0] FOLD_PH = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] NBYTES  = PH_W'(BYTES_PER_WORD);

  logic            busy;
  logic [PH_W-1:0] phase;
  logic [RD_W-1:0] round;

  sm4ks_ctrl #(.ROUNDS(ROUNDS), .PHASES(PHASES)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .phase (phase),
    .round (round)
  );

  // round phases: 1..BYTES substitute one byte each, last phase folds
  logic comp_rnd, sub_en, fold_en, del_en;
  assign comp_rnd = busy && (round < RD_W'(ROUNDS));
  assign sub_en   = comp_rnd && (phase != '0) && (phase <= NBYTES);
  assign fold_en  = comp_rnd && (phase == FOLD_PH);
  assign del_en   = busy && (round != '0) && (phase < NBYTES);

  byte_t ck_byte;

  sm4ks_ckgen #(.STEP(CK_STEP)) u_ckgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .adv     (sub_en && !start),
    .ck_byte (ck_byte)
  );

  word_t kw_q [KEY_WORDS];
  word_t kw_d [KEY_WORDS];
  word_t sacc_q, sacc_d;
  word_t hold_q, hold_d;
  byte_t out_q, out_d;
  logic  vld_q, vld_d;

  // XOR of the three upper key words, one byte picked per phase
  word_t            mix;
  logic [SEL_W-1:0] sub_sel;
  logic [SEL_W-1:0] del_sel;
  byte_t            mix_byte;
  byte_t            sbox_in, sbox_out;
  word_t            lp_out;
  word_t            rk_new;

  always_comb begin
    mix = '0;
    for (int w = 1; w < KEY_WORDS; w++) mix = mix ^ kw_q[w];
    sub_sel  = SEL_W'(phase - 1'b1);
    del_sel  = SEL_W'(phase);
    mix_byte = byte_t'(mix >> (BYTE_W * (BYTES_PER_WORD - 1 - int'(sub_sel))));
    sbox_in  = mix_byte ^ ck_byte;
  end

  sm4ks_sbox u_sbox (
    .din  (sbox_in),
    .dout (sbox_out)
  );

  sm4ks_lprime #(.ROT_A(13), .ROT_B(23)) u_lprime (
    .din  (sacc_q),
    .dout (lp_out)
  );

  assign rk_new = kw_q[0] ^ lp_out;

  always_comb begin
    kw_d   = kw_q;
    sacc_d = sacc_q;
    hold_d = hold_q;
    out_d  = out_q;
    vld_d  = 1'b0;
    if (start) begin
      for (int w = 0; w < KEY_WORDS; w++) begin
        kw_d[w] = master_key[KEY_W-1-w*WORD_W -: WORD_W]
                ^ FAMILY_KEY[KEY_W-1-w*WORD_W -: WORD_W];
      end
    end else begin
      if (sub_en) sacc_d = {sacc_q[WORD_W-BYTE_W-1:0], sbox_out};
      if (fold_en) begin
        for (int w = 0; w < KEY_WORDS - 1; w++) kw_d[w] = kw_q[w+1];
        kw_d[KEY_WORDS-1] = rk_new;
        hold_d            = rk_new;
      end
      if (del_en) begin
        out_d = byte_t'(hold_q >> (BYTE_W * (BYTES_PER_WORD - 1 - int'(del_sel))));
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < KEY_WORDS; w++) kw_q[w] <= '0;
      sacc_q <= '0;
      hold_q <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      kw_q   <= kw_d;
      sacc_q <= sacc_d;
      hold_q <= hold_d;
      out_q  <= out_d;
      vld_q  <= vld_d;
    end
  end

  assign rk_byte  = out_q;
  assign rk_valid = vld_q;

  // R3
  ck_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_en |-> (ck_byte ==
      byte_t'((int'(round) * BYTES_PER_WORD + int'(phase) - 1) * CK_STEP)));

  // R4
  key_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_en && !start) |=> (kw_q[0] == $past(kw_q[1])));

  // R5
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rk_valid) |-> (phase == PH_W'(1)));

  // R6
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |-> $past(busy));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(rk_byte) && !rk_valid));

endmodule

// File: tb/tb_sm4_keysched_serial.sv
`timescale 1ns/1ps
module tb_sm4_keysched_serial;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [127:0] master_key;
  logic [7:0]   rk_byte;
  logic         rk_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  sm4_keysched_serial dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .master_key (master_key),
    .rk_byte    (rk_byte),
    .rk_valid   (rk_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  sb_tab [256];
  logic [31:0] exp_rk [32];
  logic [31:0] got_rk [32];
  int          got_cnt;

  localparam logic [127:0] STD_KEY = 128'h01234567_89ABCDEF_FEDCBA98_76543210;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, expv);
    end
  endtask

  // field multiply, high bit of b first
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      r = r[7] ? ((r << 1) ^ 8'hF5) : (r << 1);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [7:0] m_aff(input logic [7:0] x);
    logic [7:0] y;
    logic [7:0] mask;
    for (int i = 0; i < 8; i++) begin
      mask = (8'hA7 << i) | (8'hA7 >> (8 - i));
      y[i] = (^(x & mask)) ^ (8'hD3 >> i);
    end
    return y;
  endfunction

  task automatic build_sbox();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] a;
      logic [7:0] inv;
      a   = m_aff(8'(v));
      inv = 8'h00;
      for (int c = 1; c < 256; c++) begin
        if (m_mul(a, 8'(c)) == 8'h01) inv = 8'(c);
      end
      sb_tab[v] = m_aff(inv);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  // R3: constant byte j of round i is (28*i + 7*j) mod 256
  function automatic logic [31:0] ck_word(input int i);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) w[31-8*j -: 8] = 8'((28 * i + 7 * j) % 256);
    return w;
  endfunction

  task automatic model(input logic [127:0] mk);
    logic [127:0] fk;
    logic [31:0]  k [4];
    logic [31:0]  t, s;
    fk = 128'hA3B1BAC6_56AA3350_677D9197_B27022DC;
    for (int w = 0; w < 4; w++) k[w] = mk[127-32*w -: 32] ^ fk[127-32*w -: 32];
    for (int i = 0; i < 32; i++) begin
      t = k[1] ^ k[2] ^ k[3] ^ ck_word(i);
      for (int j = 0; j < 4; j++) s[31-8*j -: 8] = sb_tab[t[31-8*j -: 8]];
      exp_rk[i] = k[0] ^ s ^ rotl(s, 13) ^ rotl(s, 23);
      k[0] = k[1]; k[1] = k[2]; k[2] = k[3]; k[3] = exp_rk[i];
    end
  endtask

  // start pulse straddles edge 0; then ncyc cycles sampled on falling edges
  task automatic run_key(input logic [127:0] mk, input int ncyc, input bit full);
    model(mk);
    got_cnt = 0;
    for (int i = 0; i < 32; i++) got_rk[i] = 32'h0;
    @(negedge clk);
    master_key = mk;
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
    master_key = {$urandom, $urandom, $urandom, $urandom};
    for (int n = 1; n <= ncyc; n++) begin
      int  off, key_i, byte_j;
      bit  exp_v;
      @(negedge clk);
      off    = n - 7;
      key_i  = (off >= 0) ? off / 6 : 0;
      byte_j = (off >= 0) ? off % 6 : 0;
      exp_v  = (off >= 0) && (byte_j < 4) && (key_i < 32);
      // R5: strobe due after edge 6*i+7+j
      chk(rk_valid == exp_v, "R5", $sformatf("strobe at edge %0d", n),
          32'(rk_valid), 32'(exp_v));
      if (rk_valid) got_cnt++;
      if (exp_v) begin
        got_rk[key_i][31-8*byte_j -: 8] = rk_byte;
        chk(rk_byte == exp_rk[key_i][31-8*byte_j -: 8], "R2",
            $sformatf("key %0d byte %0d", key_i, byte_j),
            32'(rk_byte), 32'(exp_rk[key_i][31-8*byte_j -: 8]));
      end else if (full && n > 196) begin
        chk(rk_byte == exp_rk[31][7:0], "R7",
            $sformatf("held byte at edge %0d", n),
            32'(rk_byte), 32'(exp_rk[31][7:0]));
      end
    end
    if (full) begin
      chk(got_cnt == 128, "R6", "valid byte count", 32'(got_cnt), 32'd128);
      for (int i = 0; i < 32; i++) begin
        // R4: chained rounds give the whole key sequence
        chk(got_rk[i] == exp_rk[i], "R4", $sformatf("assembled key %0d", i),
            got_rk[i], exp_rk[i]);
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    rst_n      = 1'b0;
    start      = 1'b0;
    master_key = '0;
    build_sbox();
    repeat (3) @(negedge clk);
    // R8: outputs quiet in reset
    chk(rk_valid == 1'b0, "R8", "valid in reset", 32'(rk_valid), 32'd0);
    chk(rk_byte == 8'h00, "R8", "byte in reset", 32'(rk_byte), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rk_valid == 1'b0, "R8", "valid after reset", 32'(rk_valid), 32'd0);
    chk(rk_byte == 8'h00, "R8", "byte after reset", 32'(rk_byte), 32'd0);

    // R2: bench S-box anchors
    chk(sb_tab[0] == 8'hD6, "R2", "sbox(00)", 32'(sb_tab[0]), 32'hD6);
    chk(sb_tab[1] == 8'h90, "R2", "sbox(01)", 32'(sb_tab[1]), 32'h90);
    // R3: first constant word
    chk(ck_word(0) == 32'h00070E15, "R3", "CK0", ck_word(0), 32'h00070E15);

    // R1, R9: standard key
    run_key(STD_KEY, 210, 1'b1);
    chk(got_rk[0] == 32'hF12186F9, "R9", "std rk0", got_rk[0], 32'hF12186F9);
    chk(got_rk[31] == 32'h9124A012, "R9", "std rk31", got_rk[31], 32'h9124A012);
    // R3: second key depends on the constants continuing past round 0
    chk(got_rk[1] == exp_rk[1], "R3", "std rk1", got_rk[1], exp_rk[1]);

    // R7: stays idle and holding well after the run
    repeat (25) @(negedge clk);
    chk(rk_valid == 1'b0, "R7", "idle strobe", 32'(rk_valid), 32'd0);
    chk(rk_byte == 8'h12, "R7", "idle held byte", 32'(rk_byte), 32'h12);

    // directed corner keys
    run_key(128'h0, 210, 1'b1);
    run_key({128{1'b1}}, 210, 1'b1);

    // random keys
    for (int r = 0; r < 3; r++) begin
      run_key({$urandom, $urandom, $urandom, $urandom}, 210, 1'b1);
    end

    // R1: abort mid-run, restart with the standard key
    run_key({$urandom, $urandom, $urandom, $urandom}, 45, 1'b0);
    run_key(STD_KEY, 210, 1'b1);
    chk(got_rk[0] == 32'hF12186F9, "R1", "rk0 after restart", got_rk[0], 32'hF12186F9);
    chk(got_rk[31] == 32'h9124A012, "R1", "rk31 after restart", got_rk[31], 32'h9124A012);

    // R1: restart right at a byte window, back to back
    run_key({$urandom, $urandom, $urandom, $urandom}, 8, 1'b0);
    run_key({$urandom, $urandom, $urandom, $urandom}, 210, 1'b1);

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule